// File: doc/BRIEF.md
# Software-Generated Interrupt Dispatcher

This block turns software interrupt requests into pending software-generated interrupts on a set of target processors. A processor writes a 32-bit trigger word that names an interrupt ID (0 to 15) and a way of selecting targets. For every selected target, the block records the requesting processor in a per-target, per-ID source bitmap and marks the ID pending on that target. The pending vector goes to a priority arbiter outside this block.

When a target processor acknowledges an ID, the block picks the lowest-numbered processor that still has a request outstanding for that ID, removes it from the bitmap, and returns the ID together with that source number. The ID stays pending until the bitmap is empty. Byte-wide set and clear writes give software direct access to the source bitmaps. A variant parameter removes those byte-wide registers.

Acknowledges go through a two-state machine. `AK_IDLE` waits for a request. Transition `T_ACCEPT` latches the requested CPU and ID and enters `AK_RESOLVE`. In `AK_RESOLVE` the latched request is resolved against the bitmaps after that cycle's writes have been applied. Transition `T_CHAIN` stays in `AK_RESOLVE` when another request arrives. Transition `T_DRAIN` returns to `AK_IDLE` when none does.

Top module: `sgi_dispatch`

## Requirements
- R1: After reset every bit of `pend_o` is 0, and `ack_valid` and `ack_err` are 0.
- R2: A trigger carries the ID in bits 9:0, the target list in bits 23:16 (bit 16+n selects CPU n) and the filter in bits 25:24. Filter value 0 uses the target list, and list bits for CPUs at or above NCPU are ignored. A trigger whose ID is NSGI or above changes nothing. Pending bit `pend_o[t*NSGI+id]` belongs to target t.
- R3: Filter value 1 selects every CPU except the requester.
- R4: Filter value 2 selects only the requester. Filter value 3 selects all CPUs, including the requester.
- R5: For each selected target, the requester's bit is ORed into that target's bitmap for the ID, and the ID becomes pending on that target.
- R6: An acknowledge request sampled at one rising edge is answered after the next rising edge. The answer is `ack_valid`=1 and `ack_value` = ID in bits 9:0 with the lowest set source number in bits 12:10. That source bit is then cleared.
- R7: The ID stays pending on the acknowledging CPU until its source bitmap becomes empty.
- R8: An acknowledge whose bitmap is empty returns `ack_value`=1023 with `ack_err`=1, and changes no pending bit.
- R9: A byte clear write (`pbw_clear`=1) from CPU c for an ID clears the given source bits in c's bitmap. If the bitmap becomes empty, it clears the ID's pending bit on c.
- R10: A byte set write (`pbw_clear`=0) from CPU c ORs the given source bits into c's bitmap for the ID and marks the ID pending on c.
- R11: With HAS_SRC_REGS=0, byte writes have no effect on any pending bit or bitmap.
- R12: A trigger sampled at the same edge as an acknowledge request, or at the edge where that request is resolved, is applied before the acknowledge picks its source. No source bit is lost.
- R13: Pending bits change only at an edge where a trigger, a byte write or an acknowledge resolution is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_valid | input | 1 | Trigger word write strobe |
| trig_cpu | input | CPU_W (2) | Requesting CPU of the trigger |
| trig_word | input | 32 | Trigger word |
| pbw_valid | input | 1 | Byte write strobe to a per-source register |
| pbw_clear | input | 1 | 1 = clear-pending register, 0 = set-pending register |
| pbw_cpu | input | CPU_W (2) | CPU issuing the byte write |
| pbw_id | input | IDW (4) | Interrupt ID addressed |
| pbw_bits | input | 8 | Source bits written (bit n = CPU n) |
| ack_req | input | 1 | Acknowledge request |
| ack_cpu | input | CPU_W (2) | Acknowledging CPU |
| ack_id | input | IDW (4) | Acknowledged ID |
| pend_o | output | NCPU*NSGI (64) | Pending bits per target and ID |
| ack_valid | output | 1 | Acknowledge answer valid |
| ack_value | output | 13 | ID in 9:0, source CPU in 12:10 |
| ack_err | output | 1 | Acknowledge found an empty bitmap |

## Verification
A trigger write and an acknowledge resolution can hit the same bitmap in one cycle. The bench sets this up on an empty bitmap, in two ways. In the first, the trigger is driven in the same cycle as the acknowledge request. In the second, it is driven in the following cycle, while the request is being resolved. Each case passes only if the answer names the triggering CPU and no error is reported.

// File: rtl/sgi_pkg.sv
package sgi_pkg;

    // Target selection field of the trigger word (bits 25:24)
    typedef enum logic [1:0] {
        FLT_LIST   = 2'd0,
        FLT_OTHERS = 2'd1,
        FLT_SELF   = 2'd2,
        FLT_ALL    = 2'd3
    } sgi_filter_e;

    // Acknowledge sequencing
    typedef enum logic {
        AK_IDLE    = 1'b0,
        AK_RESOLVE = 1'b1
    } ack_state_e;

    localparam int unsigned ID_FIELD_W  = 10;
    localparam int unsigned SRC_FIELD_W = 3;
    localparam int unsigned ACK_W       = ID_FIELD_W + SRC_FIELD_W;
    localparam logic [ACK_W-1:0] ACK_NONE = ACK_W'(1023);

endpackage

// File: rtl/sgi_trig_decode.sv
module sgi_trig_decode
    import sgi_pkg::*;
#(
    parameter int unsigned NCPU  = 4,
    parameter int unsigned NSGI  = 16,
    parameter int unsigned CPU_W = 2,
    parameter int unsigned IDW   = 4
) (
    input  logic             valid,
    input  logic [CPU_W-1:0] req_cpu,
    input  logic [31:0]      word,
    output logic             hit,
    output logic [IDW-1:0]   id,
    output logic [NCPU-1:0]  tgt_mask,
    output logic [NCPU-1:0]  src_bit
);
    localparam logic [NCPU-1:0] ALL_CPUS = '1;

    sgi_filter_e filt;
    logic [NCPU-1:0] list_bits;

    assign filt      = sgi_filter_e'(word[25:24]);
    assign list_bits = word[16 +: NCPU];
    assign src_bit   = NCPU'(1) << req_cpu;
    assign id        = word[IDW-1:0];
    assign hit       = valid && (word[ID_FIELD_W-1:0] < ID_FIELD_W'(NSGI));

    always_comb begin
        tgt_mask = '0;
        unique case (filt)
            FLT_LIST:   tgt_mask = list_bits & ALL_CPUS;
            FLT_OTHERS: tgt_mask = ALL_CPUS & ~src_bit;
            FLT_SELF:   tgt_mask = src_bit;
            FLT_ALL:    tgt_mask = ALL_CPUS;
            default:    tgt_mask = '0;
        endcase
    end

endmodule

// File: rtl/sgi_src_bank.sv
module sgi_src_bank #(
    parameter int unsigned NCPU  = 4,
    parameter int unsigned NSGI  = 16,
    parameter int unsigned CPU_W = 2,
    parameter int unsigned IDW   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    // trigger contribution
    input  logic             trig_hit,
    input  logic [IDW-1:0]   trig_id,
    input  logic [NCPU-1:0]  trig_src,
    // byte-wide set / clear
    input  logic             bw_hit,
    input  logic             bw_clear,
    input  logic [IDW-1:0]   bw_id,
    input  logic [NCPU-1:0]  bw_bits,
    // acknowledge resolution
    input  logic             ack_hit,
    input  logic [IDW-1:0]   ack_id,
    output logic             ack_found,
    output logic [CPU_W-1:0] ack_src,
    output logic [NSGI-1:0]  pend
);
    logic [NSGI-1:0][NCPU-1:0] map_q, map_d;
    logic [NSGI-1:0]           pend_q, pend_d;
    logic [NCPU-1:0]           cur;

    always_comb begin
        map_d  = map_q;
        pend_d = pend_q;

        // step 1: trigger write
        if (trig_hit) begin
            map_d[trig_id]  = map_d[trig_id] | trig_src;
            pend_d[trig_id] = 1'b1;
        end

        // step 2: byte set / clear
        if (bw_hit) begin
            if (bw_clear) begin
                map_d[bw_id] = map_d[bw_id] & ~bw_bits;
                if (map_d[bw_id] == '0) begin
                    pend_d[bw_id] = 1'b0;
                end
            end else begin
                map_d[bw_id]  = map_d[bw_id] | bw_bits;
                pend_d[bw_id] = 1'b1;
            end
        end

        // step 3: acknowledge picks the lowest source of the updated map
        cur       = map_d[ack_id];
        ack_found = |cur;
        ack_src   = '0;
        for (int b = NCPU - 1; b >= 0; b--) begin
            if (cur[b]) begin
                ack_src = CPU_W'(b);
            end
        end
        if (ack_hit && ack_found) begin
            map_d[ack_id][ack_src] = 1'b0;
            if (map_d[ack_id] == '0) begin
                pend_d[ack_id] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_q  <= '0;
            pend_q <= '0;
        end else begin
            map_q  <= map_d;
            pend_q <= pend_d;
        end
    end

    assign pend = pend_q;

endmodule

// File: rtl/sgi_ack_ctrl.sv
module sgi_ack_ctrl
    import sgi_pkg::*;
#(
    parameter int unsigned NCPU  = 4,
    parameter int unsigned CPU_W = 2,
    parameter int unsigned IDW   = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ack_req,
    input  logic [CPU_W-1:0]      ack_cpu,
    input  logic [IDW-1:0]        ack_id,
    input  logic [NCPU-1:0]       found_vec,
    input  logic [NCPU*CPU_W-1:0] src_flat,
    output logic                  resolving,
    output logic [CPU_W-1:0]      held_cpu,
    output logic [IDW-1:0]        held_id,
    output logic                  ack_valid,
    output logic [ACK_W-1:0]      ack_value,
    output logic                  ack_err
);
    ack_state_e state_q, state_d;
    logic       sel_found;
    logic [CPU_W-1:0] sel_src;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= AK_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state: T_ACCEPT, T_CHAIN, T_DRAIN
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            AK_IDLE:    state_d = ack_req ? AK_RESOLVE : AK_IDLE;
            AK_RESOLVE: state_d = ack_req ? AK_RESOLVE : AK_IDLE;
            default:    state_d = AK_IDLE;
        endcase
    end

    // request latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_cpu <= '0;
            held_id  <= '0;
        end else if (ack_req) begin
            held_cpu <= ack_cpu;
            held_id  <= ack_id;
        end
    end

    assign resolving = (state_q == AK_RESOLVE);
    assign sel_found = found_vec[held_cpu];
    assign sel_src   = src_flat[held_cpu*CPU_W +: CPU_W];

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_valid <= 1'b0;
            ack_value <= '0;
            ack_err   <= 1'b0;
        end else begin
            ack_valid <= resolving;
            ack_err   <= resolving && !sel_found;
            if (resolving) begin
                if (sel_found) begin
                    ack_value <= {SRC_FIELD_W'(sel_src), ID_FIELD_W'(held_id)};
                end else begin
                    ack_value <= ACK_NONE;
                end
            end
        end
    end

endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
    import sgi_pkg::*;
#(
    parameter int unsigned NCPU         = 4,
    parameter int unsigned NSGI         = 16,
    parameter bit          HAS_SRC_REGS = 1'b1,
    localparam int unsigned CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1,
    localparam int unsigned IDW   = (NSGI > 1) ? $clog2(NSGI) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 trig_valid,
    input  logic [CPU_W-1:0]     trig_cpu,
    input  logic [31:0]          trig_word,
    input  logic                 pbw_valid,
    input  logic                 pbw_clear,
    input  logic [CPU_W-1:0]     pbw_cpu,
    input  logic [IDW-1:0]       pbw_id,
    input  logic [7:0]           pbw_bits,
    input  logic                 ack_req,
    input  logic [CPU_W-1:0]     ack_cpu,
    input  logic [IDW-1:0]       ack_id,
    output logic [NCPU*NSGI-1:0] pend_o,
    output logic                 ack_valid,
    output logic [12:0]          ack_value,
    output logic                 ack_err
);
    logic             t_hit;
    logic [IDW-1:0]   t_id;
    logic [NCPU-1:0]  t_mask;
    logic [NCPU-1:0]  t_src;

    logic             resolving;
    logic [CPU_W-1:0] held_cpu;
    logic [IDW-1:0]   held_id;
    logic [NCPU-1:0]       found_vec;
    logic [NCPU*CPU_W-1:0] src_flat;
    logic [NCPU-1:0]       bw_bits_n;

    assign bw_bits_n = pbw_bits[NCPU-1:0];

    sgi_trig_decode #(
        .NCPU(NCPU), .NSGI(NSGI), .CPU_W(CPU_W), .IDW(IDW)
    ) u_decode (
        .valid    (trig_valid),
        .req_cpu  (trig_cpu),
        .word     (trig_word),
        .hit      (t_hit),
        .id       (t_id),
        .tgt_mask (t_mask),
        .src_bit  (t_src)
    );

    sgi_ack_ctrl #(
        .NCPU(NCPU), .CPU_W(CPU_W), .IDW(IDW)
    ) u_ack (
        .clk       (clk),
        .rst_n     (rst_n),
        .ack_req   (ack_req),
        .ack_cpu   (ack_cpu),
        .ack_id    (ack_id),
        .found_vec (found_vec),
        .src_flat  (src_flat),
        .resolving (resolving),
        .held_cpu  (held_cpu),
        .held_id   (held_id),
        .ack_valid (ack_valid),
        .ack_value (ack_value),
        .ack_err   (ack_err)
    );

    for (genvar t = 0; t < NCPU; t++) begin : g_tgt
        logic bw_hit;

        if (HAS_SRC_REGS) begin : g_regs
            assign bw_hit = pbw_valid && (pbw_cpu == CPU_W'(t));
        end else begin : g_legacy
            assign bw_hit = 1'b0;
        end

        sgi_src_bank #(
            .NCPU(NCPU), .NSGI(NSGI), .CPU_W(CPU_W), .IDW(IDW)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .trig_hit  (t_hit && t_mask[t]),
            .trig_id   (t_id),
            .trig_src  (t_src),
            .bw_hit    (bw_hit),
            .bw_clear  (pbw_clear),
            .bw_id     (pbw_id),
            .bw_bits   (bw_bits_n),
            .ack_hit   (resolving && (held_cpu == CPU_W'(t))),
            .ack_id    (held_id),
            .ack_found (found_vec[t]),
            .ack_src   (src_flat[t*CPU_W +: CPU_W]),
            .pend      (pend_o[t*NSGI +: NSGI])
        );
    end

endmodule

// File: rtl/sgi_dispatch_chk.sv
module sgi_dispatch_chk #(
    parameter int unsigned NCPU = 4,
    parameter int unsigned NSGI = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 trig_valid,
    input logic                 pbw_valid,
    input logic                 ack_req,
    input logic [NCPU*NSGI-1:0] pend_o,
    input logic                 ack_valid,
    input logic [12:0]          ack_value,
    input logic                 ack_err
);
    AST_ACK_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req |=> ##1 ack_valid);                                   // R6

    AST_ERR_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_err) |-> (ack_value == 13'd1023));           // R8

    AST_ERR_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        ack_err |-> ack_valid);                                       // R8

    AST_SRC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && !ack_err) |->
            ((32'(ack_value[12:10]) < NCPU) && (32'(ack_value[9:0]) < NSGI))); // R6

    AST_PEND_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig_valid && !pbw_valid && !$past(ack_req)) |=> $stable(pend_o)); // R13

endmodule

bind sgi_dispatch sgi_dispatch_chk #(.NCPU(NCPU), .NSGI(NSGI)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_valid (trig_valid),
    .pbw_valid  (pbw_valid),
    .ack_req    (ack_req),
    .pend_o     (pend_o),
    .ack_valid  (ack_valid),
    .ack_value  (ack_value),
    .ack_err    (ack_err)
);

// File: tb/sgi_dispatch_tb.sv
module sgi_dispatch_tb;
    localparam int NCPU = 4;
    localparam int NSGI = 16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        trig_valid;
    logic [1:0]  trig_cpu;
    logic [31:0] trig_word;
    logic        pbw_valid, pbw_clear;
    logic [1:0]  pbw_cpu;
    logic [3:0]  pbw_id;
    logic [7:0]  pbw_bits;
    logic        ack_req;
    logic [1:0]  ack_cpu;
    logic [3:0]  ack_id;
    logic [63:0] pend_o, lg_pend;
    logic        ack_valid, ack_err, lg_valid, lg_err;
    logic [12:0] ack_value, lg_value;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    sgi_dispatch u_dut (
        .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .trig_cpu(trig_cpu),
        .trig_word(trig_word), .pbw_valid(pbw_valid), .pbw_clear(pbw_clear),
        .pbw_cpu(pbw_cpu), .pbw_id(pbw_id), .pbw_bits(pbw_bits), .ack_req(ack_req),
        .ack_cpu(ack_cpu), .ack_id(ack_id), .pend_o(pend_o), .ack_valid(ack_valid),
        .ack_value(ack_value), .ack_err(ack_err)
    );

    sgi_dispatch #(.HAS_SRC_REGS(1'b0)) u_legacy (
        .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .trig_cpu(trig_cpu),
        .trig_word(trig_word), .pbw_valid(pbw_valid), .pbw_clear(pbw_clear),
        .pbw_cpu(pbw_cpu), .pbw_id(pbw_id), .pbw_bits(pbw_bits), .ack_req(ack_req),
        .ack_cpu(ack_cpu), .ack_id(ack_id), .pend_o(lg_pend), .ack_valid(lg_valid),
        .ack_value(lg_value), .ack_err(lg_err)
    );

    function automatic logic [31:0] tw(int id, int lst, int flt);
        return (32'(flt) << 24) | (32'(lst) << 16) | 32'(id);
    endfunction

    function automatic logic [3:0] pcol(int id);
        logic [3:0] r;
        for (int t = 0; t < NCPU; t++) r[t] = pend_o[t*NSGI + id];
        return r;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; trig_valid = 0; trig_cpu = 0; trig_word = 0;
        pbw_valid = 0; pbw_clear = 0; pbw_cpu = 0; pbw_id = 0; pbw_bits = 0;
        ack_req = 0; ack_cpu = 0; ack_id = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
    endtask

    task automatic send_trig(input int cpu, input logic [31:0] w);
        @(negedge clk);
        trig_valid = 1; trig_cpu = 2'(cpu); trig_word = w;
        @(negedge clk);
        trig_valid = 0;
    endtask

    task automatic send_bw(input int cpu, input bit clr, input int id, input int bits);
        @(negedge clk);
        pbw_valid = 1; pbw_clear = clr; pbw_cpu = 2'(cpu); pbw_id = 4'(id); pbw_bits = 8'(bits);
        @(negedge clk);
        pbw_valid = 0;
    endtask

    task automatic ack_expect(input int cpu, input int id, input int expv, input bit experr,
                              input string tag);
        @(negedge clk);
        ack_req = 1; ack_cpu = 2'(cpu); ack_id = 4'(id);
        @(negedge clk);
        ack_req = 0;
        @(posedge clk); #1;
        check({tag, " valid"}, 64'(ack_valid), 64'd1);
        check({tag, " value"}, 64'(ack_value), 64'(expv));
        check({tag, " err"},   64'(ack_err),   64'(experr));
    endtask

    task automatic t_reset();
        do_reset();
        #1;
        check("R1 pend", pend_o, 64'd0);
        check("R1 valid", 64'(ack_valid), 64'd0);
        check("R1 err", 64'(ack_err), 64'd0);
    endtask

    task automatic t_filters();
        do_reset();
        send_trig(1, tw(3, 8'hF5, 0));
        check("R2 list masked", 64'(pcol(3)), 64'b0101);
        send_trig(1, tw(16, 8'hFF, 3));
        check("R2 id out of range", pend_o, 64'd1 << 3 | 64'd1 << (2*NSGI + 3));
        send_trig(2, tw(7, 0, 1));
        check("R3 others", 64'(pcol(7)), 64'b1011);
        send_trig(3, tw(9, 0, 2));
        check("R4 self", 64'(pcol(9)), 64'b1000);
        send_trig(0, tw(11, 0, 3));
        check("R4 all", 64'(pcol(11)), 64'b1111);
    endtask

    task automatic t_sources();
        do_reset();
        send_trig(2, tw(4, 8'h01, 0));
        send_trig(1, tw(4, 8'h01, 0));
        check("R5 pending", 64'(pcol(4)), 64'b0001);
        ack_expect(0, 4, 13'h404, 0, "R6 lowest source");
        check("R7 still pending", 64'(pcol(4)), 64'b0001);
        ack_expect(0, 4, 13'h804, 0, "R6 next source");
        check("R7 drained", 64'(pcol(4)), 64'b0000);
        ack_expect(0, 4, 1023, 1, "R8 empty");
        check("R8 pend unchanged", pend_o, 64'd0);
    endtask

    task automatic t_byte_clear();
        do_reset();
        send_trig(1, tw(6, 8'h04, 0));
        send_trig(3, tw(6, 8'h04, 0));
        send_bw(2, 1, 6, 8'h02);
        check("R9 partial clear", 64'(pcol(6)), 64'b0100);
        send_bw(2, 1, 6, 8'h08);
        check("R9 full clear", 64'(pcol(6)), 64'b0000);
        ack_expect(2, 6, 1023, 1, "R9 bitmap empty");
    endtask

    task automatic t_byte_set();
        do_reset();
        send_bw(1, 0, 2, 8'h05);
        check("R10 set pending", 64'(pcol(2)), 64'b0010);
        check("R11 legacy ignores", lg_pend, 64'd0);
        ack_expect(1, 2, 13'h002, 0, "R10 src0");
        ack_expect(1, 2, 13'h802, 0, "R10 src2");
        check("R10 drained", 64'(pcol(2)), 64'b0000);
        send_trig(2, tw(5, 0, 2));
        check("R11 legacy trigger", lg_pend, 64'd1 << (2*NSGI + 5));
    endtask

    task automatic t_collide();
        do_reset();
        // trigger and acknowledge request in the same cycle
        @(negedge clk);
        ack_req = 1; ack_cpu = 0; ack_id = 5;
        trig_valid = 1; trig_cpu = 2; trig_word = tw(5, 8'h01, 0);
        @(negedge clk);
        ack_req = 0; trig_valid = 0;
        @(posedge clk); #1;
        check("R12 same cycle value", 64'(ack_value), 64'h805);
        check("R12 same cycle err", 64'(ack_err), 64'd0);
        check("R12 same cycle pend", 64'(pcol(5)), 64'b0000);
        // trigger during the resolution cycle
        @(negedge clk);
        ack_req = 1; ack_cpu = 0; ack_id = 5;
        @(negedge clk);
        ack_req = 0;
        trig_valid = 1; trig_cpu = 3; trig_word = tw(5, 8'h01, 0);
        @(posedge clk); #1;
        check("R12 resolve cycle value", 64'(ack_value), 64'hC05);
        check("R12 resolve cycle err", 64'(ack_err), 64'd0);
        @(negedge clk) trig_valid = 0;
        check("R12 resolve cycle pend", 64'(pcol(5)), 64'b0000);
        @(posedge clk); #1;
        check("R13 pend quiet", pend_o, 64'd0);
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_filters();
        t_sources();
        t_byte_clear();
        t_byte_set();
        t_collide();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule